// File: doc/BRIEF.md
# Timing Reference Sequence Detector with Line Lock

This block watches a stream of parallel video words, each qualified by a valid input. It finds the four-word timing reference sequence. The sequence is an all-ones word, two all-zero words, and then a status word. The block raises a one-cycle flag for the start of each sequence. It decodes the status word into field, vertical blanking and horizontal blanking levels. It pulses a separate flag when the status word marks end of active video.

A lock tracker measures the spacing between successive end-of-active-video sequences. The spacing is counted in valid words. The lock flag rises once the spacing has repeated consistently. Any change in spacing drops the lock, and the count starts again. Downstream logic uses the flags to frame lines and uses the lock to decide when the timing can be trusted.

The preamble matcher is a four-state machine:
- `M_IDLE`: waiting for an all-ones word.
- `M_GOT1`: one all-ones word seen.
- `M_GOT2`: all-ones then one zero word seen.
- `M_GOT3`: the full preamble seen; the status word is expected next.

The matcher has these transitions on each valid word:
- *start*: all-ones from `M_IDLE`, `M_GOT1` or `M_GOT2` goes to `M_GOT1`.
- *advance*: zero from `M_GOT1` goes to `M_GOT2`, and zero from `M_GOT2` goes to `M_GOT3`.
- *break*: any other word in `M_GOT1` or `M_GOT2` goes to `M_IDLE`.
- *finish*: any word in `M_GOT3` goes to `M_IDLE`.

The lock tracker is a three-state machine:
- `L_WAIT`: no end-of-video sequence seen yet.
- `L_MEASURE`: counting equal spacings.
- `L_LOCKED`: locked.

The tracker has these transitions, each taken on an end-of-video status word:
- *first*: `L_WAIT` goes to `L_MEASURE`.
- *match*: `L_MEASURE` stays in `L_MEASURE` while the run is still short.
- *mismatch*: `L_MEASURE` restarts its run.
- *reach*: `L_MEASURE` goes to `L_LOCKED` when the run reaches `LOCK_RUN`.
- *lose*: `L_LOCKED` goes to `L_MEASURE` on a spacing that differs.

Top module: `trs_lock_detect`

## Requirements
- R1: While reset is low, and in the first cycle after it, every output is 0. Reset is active-low and asynchronous.
- R2: `trs_flag` is high for exactly the one cycle after a valid all-ones word (3FF) is clocked in. This applies in every matcher state except the one awaiting the status word.
- R3: A valid all-ones, zero, zero sequence followed by a valid status word with bit 9 set is accepted. In the cycle after the status word, `fld` shows bit 8, `vblank` shows bit 7 and `hblank` shows bit 6 of that word. The three outputs hold those values until the next accepted status word.
- R4: `eav_flag` is high for one cycle after an accepted status word whose bit 6 (H) is 1. The flag stays low when H is 0.
- R5: A status word with bit 9 clear is rejected. It leaves `fld`, `vblank`, `hblank` and `eav_flag` unchanged, and the matcher returns to idle.
- R6: A preamble broken by an unexpected word returns the matcher to idle. An all-ones word in the second or third position instead restarts the match as a new first word, and pulses `trs_flag`.
- R7: Words with `valid_in` low are ignored. They do not advance the matcher, raise any flag, or count toward the spacing.
- R8: The spacing is the number of valid words after one end-of-video status word, up to and including the next one. `locked` rises in the same cycle as the `eav_flag` that completes `LOCK_RUN` (6) consecutive equal spacings.
- R9: A spacing that differs from the current reference sets a new reference and restarts the run at one. When it occurs while locked, `locked` falls in the same cycle as the `eav_flag` of that sequence.
- R10: Sequences with H = 0 neither break nor advance the lock. Their words count as ordinary valid words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_in | input | WORD_W | Parallel video word |
| valid_in | input | 1 | Qualifies `word_in` |
| trs_flag | output | 1 | Start of a timing reference sequence |
| eav_flag | output | 1 | Accepted status word marks end of active video |
| fld | output | 1 | Field: 0 first, 1 second (0 for progressive) |
| vblank | output | 1 | Vertical blanking active |
| hblank | output | 1 | Horizontal blanking active |
| locked | output | 1 | Line spacing is stable |

## Verification
The end-of-video decode and the lock decision are both made on the same status word, so they change in the same cycle. The bench provokes this coincidence twice. The first time, it completes the sixth equal spacing, and the bench expects `eav_flag` and a rising `locked` in one sample. The second time, it lengthens one line by a single word while locked, and the bench expects `eav_flag` high and `locked` low in that same sample. The bench then checks that re-lock needs five further equal spacings, because the mismatching spacing itself starts the new run.

// File: rtl/trs_pkg.sv
package trs_pkg;

    typedef enum logic [1:0] {
        M_IDLE,
        M_GOT1,
        M_GOT2,
        M_GOT3
    } match_state_t;

    typedef enum logic [1:0] {
        L_WAIT,
        L_MEASURE,
        L_LOCKED
    } lock_state_t;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } fvh_t;

endpackage

// File: rtl/trs_matcher.sv
module trs_matcher
    import trs_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              valid_in,
    output logic              start_hit,
    output logic              xyz_hit
);

    match_state_t state_q, state_d;
    logic is_ones, is_zero;

    assign is_ones = (word_in == {WORD_W{1'b1}});
    assign is_zero = (word_in == {WORD_W{1'b0}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= M_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (valid_in) begin
            unique case (state_q)
                M_IDLE:  state_d = is_ones ? M_GOT1 : M_IDLE;
                M_GOT1:  state_d = is_zero ? M_GOT2 : (is_ones ? M_GOT1 : M_IDLE);
                M_GOT2:  state_d = is_zero ? M_GOT3 : (is_ones ? M_GOT1 : M_IDLE);
                M_GOT3:  state_d = M_IDLE;
                default: state_d = M_IDLE;
            endcase
        end
    end

    always_comb begin
        start_hit = 1'b0;
        xyz_hit   = 1'b0;
        if (valid_in) begin
            unique case (state_q)
                M_IDLE, M_GOT1, M_GOT2: start_hit = is_ones;
                M_GOT3:                 xyz_hit   = word_in[WORD_W-1];
                default:                start_hit = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/trs_flag_decode.sv
module trs_flag_decode
    import trs_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              start_hit,
    input  logic              xyz_hit,
    output logic              eav_hit,
    output logic              trs_flag,
    output logic              eav_flag,
    output logic              fld,
    output logic              vblank,
    output logic              hblank
);

    fvh_t fvh_q, fvh_in;

    assign fvh_in  = fvh_t'(word_in[WORD_W-2:WORD_W-4]);
    assign eav_hit = xyz_hit & fvh_in.h;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trs_flag <= 1'b0;
            eav_flag <= 1'b0;
            fvh_q    <= '0;
        end else begin
            trs_flag <= start_hit;
            eav_flag <= eav_hit;
            if (xyz_hit) fvh_q <= fvh_in;
        end
    end

    always_comb begin
        fld    = fvh_q.f;
        vblank = fvh_q.v;
        hblank = fvh_q.h;
    end

endmodule

// File: rtl/trs_lock_tracker.sv
module trs_lock_tracker
    import trs_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int LOCK_RUN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_in,
    input  logic eav_hit,
    output logic locked
);

    localparam int RUN_W = $clog2(LOCK_RUN + 1);

    lock_state_t      st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   span, ref_q, ref_d;
    logic [RUN_W-1:0] run_q, run_d;

    assign span = {1'b0, cnt_q} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (eav_hit) begin
            cnt_q <= '0;
        end else if (valid_in && (cnt_q != {CNT_W{1'b1}})) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= L_WAIT;
            run_q <= '0;
            ref_q <= '0;
        end else begin
            st_q  <= st_d;
            run_q <= run_d;
            ref_q <= ref_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        run_d = run_q;
        ref_d = ref_q;
        if (eav_hit) begin
            unique case (st_q)
                L_WAIT: begin
                    st_d  = L_MEASURE;
                    run_d = '0;
                end
                L_MEASURE: begin
                    if ((run_q == '0) || (span != ref_q)) begin
                        ref_d = span;
                        run_d = RUN_W'(1);
                    end else begin
                        run_d = run_q + 1'b1;
                        if (run_q + 1'b1 == RUN_W'(LOCK_RUN)) st_d = L_LOCKED;
                    end
                end
                L_LOCKED: begin
                    if (span != ref_q) begin
                        ref_d = span;
                        run_d = RUN_W'(1);
                        st_d  = L_MEASURE;
                    end
                end
                default: st_d = L_WAIT;
            endcase
        end
    end

    always_comb begin
        locked = (st_q == L_LOCKED);
    end

endmodule

// File: rtl/trs_lock_detect.sv
module trs_lock_detect
    import trs_pkg::*;
#(
    parameter int WORD_W   = 10,
    parameter int CNT_W    = 16,
    parameter int LOCK_RUN = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              valid_in,
    output logic              trs_flag,
    output logic              eav_flag,
    output logic              fld,
    output logic              vblank,
    output logic              hblank,
    output logic              locked
);

    logic start_hit, xyz_hit, eav_hit;

    trs_matcher #(.WORD_W(WORD_W)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_in  (word_in),
        .valid_in (valid_in),
        .start_hit(start_hit),
        .xyz_hit  (xyz_hit)
    );

    trs_flag_decode #(.WORD_W(WORD_W)) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_in  (word_in),
        .start_hit(start_hit),
        .xyz_hit  (xyz_hit),
        .eav_hit  (eav_hit),
        .trs_flag (trs_flag),
        .eav_flag (eav_flag),
        .fld      (fld),
        .vblank   (vblank),
        .hblank   (hblank)
    );

    trs_lock_tracker #(.CNT_W(CNT_W), .LOCK_RUN(LOCK_RUN)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_in(valid_in),
        .eav_hit (eav_hit),
        .locked  (locked)
    );

endmodule

// File: rtl/trs_lock_detect_chk.sv
module trs_lock_detect_chk #(
    parameter int WORD_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] word_in,
    input logic              valid_in,
    input logic              trs_flag,
    input logic              eav_flag,
    input logic              fld,
    input logic              vblank,
    input logic              hblank,
    input logic              locked
);

    a_r2_trs_not_eav: assert property (@(posedge clk) disable iff (!rst_n)
        !(trs_flag && eav_flag));

    a_r4_eav_has_h: assert property (@(posedge clk) disable iff (!rst_n)
        eav_flag |-> hblank);

    a_r4_eav_single: assert property (@(posedge clk) disable iff (!rst_n)
        eav_flag |=> !eav_flag);

    a_r7_invalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> (!trs_flag && !eav_flag && $stable({fld, vblank, hblank, locked})));

    a_r8_lock_on_eav: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> eav_flag);

    a_r9_unlock_on_eav: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> eav_flag);

endmodule

bind trs_lock_detect trs_lock_detect_chk #(.WORD_W(WORD_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .word_in (word_in),
    .valid_in(valid_in),
    .trs_flag(trs_flag),
    .eav_flag(eav_flag),
    .fld     (fld),
    .vblank  (vblank),
    .hblank  (hblank),
    .locked  (locked)
);

// File: tb/trs_lock_detect_bench.sv
module trs_lock_detect_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] word_in = '0;
    logic       valid_in = 1'b0;
    logic       trs_flag, eav_flag, fld, vblank, hblank, locked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [9:0] EAV0 = 10'h274;
    localparam logic [9:0] SAV0 = 10'h200;
    localparam logic [9:0] EAV_F1V = 10'h3C4;
    localparam logic [9:0] FILL = 10'h204;

    always #10 clk = ~clk;

    trs_lock_detect u_trs_lock_detect (
        .clk(clk), .rst_n(rst_n), .word_in(word_in), .valid_in(valid_in),
        .trs_flag(trs_flag), .eav_flag(eav_flag), .fld(fld),
        .vblank(vblank), .hblank(hblank), .locked(locked)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [9:0] w, input logic v);
        word_in  = w;
        valid_in = v;
        @(posedge clk);
        #2;
    endtask

    task automatic send_trs(input logic [9:0] xyz);
        put(10'h3FF, 1'b1);
        put(10'h000, 1'b1);
        put(10'h000, 1'b1);
        put(xyz, 1'b1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        valid_in = 1'b0;
        word_in = '0;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 outputs after reset", {26'd0, trs_flag, eav_flag, fld, vblank, hblank, locked}, 32'd0);
    endtask

    task automatic t_basic();
        put(10'h3FF, 1'b1);
        chk("R2 trs_flag on first word", trs_flag, 1);
        put(10'h000, 1'b1);
        chk("R2 trs_flag one cycle", trs_flag, 0);
        put(10'h000, 1'b1);
        put(EAV0, 1'b1);
        chk("R4 eav_flag on EAV", eav_flag, 1);
        chk("R3 fvh after EAV", {fld, vblank, hblank}, 3'b001);
        put(FILL, 1'b1);
        chk("R4 eav_flag one cycle", eav_flag, 0);
        chk("R3 hblank held", hblank, 1);
        send_trs(SAV0);
        chk("R4 no eav_flag for H=0", eav_flag, 0);
        chk("R3 fvh after SAV", {fld, vblank, hblank}, 3'b000);
        send_trs(EAV_F1V);
        chk("R3 field 2 vblank", {fld, vblank, hblank}, 3'b111);
    endtask

    task automatic t_bad_xyz();
        send_trs(10'h1C0);
        chk("R5 bit9 clear no eav", eav_flag, 0);
        chk("R5 bit9 clear fvh held", {fld, vblank, hblank}, 3'b111);
        put(10'h000, 1'b1);
        put(10'h000, 1'b1);
        put(SAV0, 1'b1);
        chk("R5 matcher idle after reject", {fld, vblank, hblank}, 3'b111);
    endtask

    task automatic t_broken();
        put(10'h3FF, 1'b1);
        put(10'h000, 1'b1);
        put(10'h155, 1'b1);
        put(10'h000, 1'b1);
        put(10'h000, 1'b1);
        put(SAV0, 1'b1);
        chk("R6 broken preamble ignored", {fld, vblank, hblank}, 3'b111);
        put(10'h3FF, 1'b1);
        put(10'h3FF, 1'b1);
        chk("R6 restart pulses trs_flag", trs_flag, 1);
        put(10'h000, 1'b1);
        put(10'h000, 1'b1);
        put(SAV0, 1'b1);
        chk("R6 restart completes", {fld, vblank, hblank}, 3'b000);
        put(10'h3FF, 1'b1);
        put(10'h000, 1'b1);
        put(10'h3FF, 1'b1);
        chk("R6 3FF in third slot restarts", trs_flag, 1);
        put(10'h000, 1'b1);
        put(10'h000, 1'b1);
        put(EAV0, 1'b1);
        chk("R6 third slot restart completes", eav_flag, 1);
    endtask

    task automatic t_invalid();
        put(10'h3FF, 1'b1);
        put(10'h155, 1'b0);
        put(10'h3FF, 1'b0);
        chk("R7 invalid 3FF no trs_flag", trs_flag, 0);
        put(10'h000, 1'b1);
        put(10'h123, 1'b0);
        put(10'h000, 1'b1);
        put(10'h3C4, 1'b0);
        chk("R7 invalid xyz ignored", {eav_flag, hblank}, 2'b01);
        put(SAV0, 1'b1);
        chk("R7 gaps do not break match", hblank, 0);
    endtask

    task automatic line_body(input int fill_a, input int fill_b, input int gaps);
        repeat (gaps) put(10'h3FF, 1'b0);
        repeat (fill_a) put(FILL, 1'b1);
        send_trs(SAV0);
        repeat (fill_b) put(FILL, 1'b1);
    endtask

    task automatic t_lock();
        do_reset();
        for (int k = 1; k <= 7; k++) begin
            send_trs(EAV0);
            chk("R8 eav during acquire", eav_flag, 1);
            chk("R8 lock after six equal spacings", locked, (k == 7));
            line_body(4, 8, 0);
        end
        chk("R10 SAV keeps lock", locked, 1);
        send_trs(EAV0);
        line_body(4, 8, 3);
        send_trs(EAV0);
        chk("R7 gaps do not change spacing", locked, 1);
        line_body(5, 8, 0);
        send_trs(EAV0);
        chk("R9 mismatch eav_flag", eav_flag, 1);
        chk("R9 mismatch drops lock", locked, 0);
        for (int k = 1; k <= 5; k++) begin
            line_body(5, 8, 0);
            send_trs(EAV0);
            chk("R9 relock needs new run", locked, (k == 5));
        end
        do_reset();
        chk("R1 reset clears lock", locked, 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_bad_xyz();
        t_broken();
        t_invalid();
        t_lock();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule